// File: doc/BRIEF.md
# USB Device Bus-Reset Handler

This block holds the small set of device-side controller registers that a USB bus reset must touch, and applies the full reset bundle to them the moment the line-level detector reports a reset. The registers are the function address, the endpoint index, one control/status register per endpoint and one interrupt-enable bit per endpoint. A sticky interrupt flag tells software that a bus reset happened.

A detector outside the block raises `bus_rst_i` for a cycle. On the next clock edge, every reset action lands at once. The address and the index go to zero. Every endpoint control/status register is cleared. Every endpoint interrupt enable is set. Each endpoint FIFO gets a one-cycle flush pulse. The reset interrupt flag is raised. Software reads and writes the registers through a simple write port and then waits for enumeration. The FIFOs themselves live elsewhere and only receive the flush pulses.

Top module: `usbd_busrst_regs`

## Requirements
- R1: A cycle with `bus_rst_i` high sets `func_addr_o` to 0 from the next cycle on.
- R2: A cycle with `bus_rst_i` high sets `ep_idx_o` to 0 from the next cycle on.
- R3: A cycle with `bus_rst_i` high drives all `NUM_EP` bits of `fifo_flush_o` high for exactly the next cycle.
- R4: A cycle with `bus_rst_i` high clears every endpoint control/status field to 0 from the next cycle on. Endpoint i occupies bits [i*CSR_W +: CSR_W] of `ep_csr_o`.
- R5: A cycle with `bus_rst_i` high sets every bit of `ep_ie_o` to 1 from the next cycle on.
- R6: A cycle with `bus_rst_i` high sets `rst_irq_o` from the next cycle on.
- R7: `rst_irq_o` stays set until software writes with `wr_sel`=4 and `wr_data[0]`=1. A write with `wr_data[0]`=0 leaves it set.
- R8: A software write in the same cycle as `bus_rst_i` is discarded, and the reset values appear instead.
- R9: Software writes take effect in the next cycle. The `wr_sel` codes are: 0 writes the address from `wr_data[6:0]`; 1 writes the index from `wr_data[3:0]`; 2 writes the control/status of endpoint `wr_ep` from `wr_data`; 3 writes the enable mask from `wr_data[NUM_EP-1:0]`.
- R10: A control/status write with `wr_ep` >= `NUM_EP` changes no register.
- R11: `fifo_flush_o` is 0 in every cycle that does not follow a bus-reset cycle.
- R12: After `rst_n` reset, the address, index and control/status registers are 0, all enables are 1, the flush pulses are 0 and `rst_irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| bus_rst_i | input | 1 | Bus reset detected strobe |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 3 | Register select (0 address, 1 index, 2 endpoint control/status, 3 enable mask, 4 interrupt clear) |
| wr_ep | input | IDX_W | Endpoint number for control/status writes |
| wr_data | input | CSR_W | Write data |
| func_addr_o | output | ADDR_W | Function address |
| ep_idx_o | output | IDX_W | Endpoint index |
| fifo_flush_o | output | NUM_EP | Per-endpoint FIFO flush pulses |
| ep_csr_o | output | NUM_EP*CSR_W | Packed endpoint control/status registers |
| ep_ie_o | output | NUM_EP | Endpoint interrupt enables |
| rst_irq_o | output | 1 | Sticky bus-reset interrupt |

## Verification
Every result of this block is one register stage away from its cause. The reset bundle, the flush pulse and software writes all show up in the cycle after the input edge that samples them. The flush pulse is gone again one cycle later.

The bench drives its inputs on the falling edge and checks on the next falling edge, which is exactly one rising edge later. For the flush pulse it checks the cycle after that as well. The collision cases use this same one-edge window, with the software write and the bus reset presented together.

// File: rtl/usbd_br_pkg.sv
package usbd_br_pkg;
  typedef enum logic [2:0] {
    SEL_ADDR = 3'd0,
    SEL_IDX  = 3'd1,
    SEL_CSR  = 3'd2,
    SEL_IE   = 3'd3,
    SEL_IRQ  = 3'd4
  } reg_sel_e;

  // endpoint i is addressed by a write when the number matches and is in range
  function automatic logic ep_hit(input int unsigned ep, input int unsigned i,
                                  input int unsigned n_ep);
    return (ep == i) && (ep < n_ep);
  endfunction
endpackage

// File: rtl/usbd_br_ctl.sv
module usbd_br_ctl
  import usbd_br_pkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int IDX_W  = 4
) (
  input  logic             bus_rst_i,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [IDX_W-1:0] wr_ep,
  input  logic             clr_bit,
  output logic             addr_we,
  output logic             idx_we,
  output logic [NUM_EP-1:0] csr_we,
  output logic             ie_we,
  output logic             irq_clr
);
  reg_sel_e sel;
  logic     sw_ok;

  assign sel   = reg_sel_e'(wr_sel);
  assign sw_ok = wr_en && !bus_rst_i;  // reset wins over software

  assign addr_we = sw_ok && (sel == SEL_ADDR);
  assign idx_we  = sw_ok && (sel == SEL_IDX);
  assign ie_we   = sw_ok && (sel == SEL_IE);
  assign irq_clr = sw_ok && (sel == SEL_IRQ) && clr_bit;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_we
    assign csr_we[i] = sw_ok && (sel == SEL_CSR) &&
                       ep_hit(int'(wr_ep), i, NUM_EP);
  end
endmodule

// File: rtl/usbd_br_devregs.sv
module usbd_br_devregs #(
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst_i,
  input  logic              addr_we,
  input  logic              idx_we,
  input  logic              irq_clr,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [IDX_W-1:0]  idx_d,
  output logic [ADDR_W-1:0] func_addr,
  output logic [IDX_W-1:0]  ep_idx,
  output logic              rst_irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_addr <= '0;
      ep_idx    <= '0;
      rst_irq   <= 1'b0;
    end else begin
      if (bus_rst_i) begin
        func_addr <= '0;
        ep_idx    <= '0;
        rst_irq   <= 1'b1;
      end else begin
        if (addr_we) func_addr <= addr_d;
        if (idx_we)  ep_idx    <= idx_d;
        if (irq_clr) rst_irq   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usbd_br_epregs.sv
module usbd_br_epregs #(
  parameter int NUM_EP = 8,
  parameter int CSR_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_rst_i,
  input  logic [NUM_EP-1:0]       csr_we,
  input  logic                    ie_we,
  input  logic [CSR_W-1:0]        wdata,
  input  logic [NUM_EP-1:0]       ie_d,
  output logic [NUM_EP*CSR_W-1:0] csr,
  output logic [NUM_EP-1:0]       ie,
  output logic [NUM_EP-1:0]       flush
);
  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        csr[i*CSR_W +: CSR_W] <= '0;
        ie[i]                 <= 1'b1;
        flush[i]              <= 1'b0;
      end else begin
        flush[i] <= bus_rst_i;
        if (bus_rst_i) begin
          csr[i*CSR_W +: CSR_W] <= '0;
          ie[i]                 <= 1'b1;
        end else begin
          if (csr_we[i]) csr[i*CSR_W +: CSR_W] <= wdata;
          if (ie_we)     ie[i] <= ie_d[i];
        end
      end
    end
  end
endmodule

// File: rtl/usbd_busrst_regs.sv
module usbd_busrst_regs #(
  parameter int NUM_EP = 8,
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 4,
  parameter int CSR_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_rst_i,
  input  logic                    wr_en,
  input  logic [2:0]              wr_sel,
  input  logic [IDX_W-1:0]        wr_ep,
  input  logic [CSR_W-1:0]        wr_data,
  output logic [ADDR_W-1:0]       func_addr_o,
  output logic [IDX_W-1:0]        ep_idx_o,
  output logic [NUM_EP-1:0]       fifo_flush_o,
  output logic [NUM_EP*CSR_W-1:0] ep_csr_o,
  output logic [NUM_EP-1:0]       ep_ie_o,
  output logic                    rst_irq_o
);
  // named internal events, visible to the bound checker
  logic              addr_we, idx_we, ie_we, irq_clr;
  logic [NUM_EP-1:0] csr_we;

  usbd_br_ctl #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_ctl (
    .bus_rst_i(bus_rst_i), .wr_en(wr_en), .wr_sel(wr_sel), .wr_ep(wr_ep),
    .clr_bit(wr_data[0]), .addr_we(addr_we), .idx_we(idx_we),
    .csr_we(csr_we), .ie_we(ie_we), .irq_clr(irq_clr)
  );

  usbd_br_devregs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dev (
    .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst_i),
    .addr_we(addr_we), .idx_we(idx_we), .irq_clr(irq_clr),
    .addr_d(wr_data[ADDR_W-1:0]), .idx_d(wr_data[IDX_W-1:0]),
    .func_addr(func_addr_o), .ep_idx(ep_idx_o), .rst_irq(rst_irq_o)
  );

  usbd_br_epregs #(.NUM_EP(NUM_EP), .CSR_W(CSR_W)) u_ep (
    .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst_i),
    .csr_we(csr_we), .ie_we(ie_we), .wdata(wr_data),
    .ie_d(wr_data[NUM_EP-1:0]), .csr(ep_csr_o), .ie(ep_ie_o),
    .flush(fifo_flush_o)
  );
endmodule

// File: rtl/usbd_busrst_regs_chk.sv
module usbd_busrst_regs_chk #(
  parameter int NUM_EP = 8,
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 4,
  parameter int CSR_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_rst_i,
  input logic                    irq_clr,
  input logic [NUM_EP-1:0]       csr_we,
  input logic [ADDR_W-1:0]       func_addr_o,
  input logic [IDX_W-1:0]        ep_idx_o,
  input logic [NUM_EP-1:0]       fifo_flush_o,
  input logic [NUM_EP*CSR_W-1:0] ep_csr_o,
  input logic [NUM_EP-1:0]       ep_ie_o,
  input logic                    rst_irq_o
);
  // R1
  addr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> func_addr_o == '0);
  // R2
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> ep_idx_o == '0);
  // R3
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> fifo_flush_o == '1);
  // R11
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst_i |=> fifo_flush_o == '0);
  // R4
  csr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> ep_csr_o == '0);
  // R5
  ie_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> ep_ie_o == '1);
  // R6
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> rst_irq_o);
  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_irq_o && !irq_clr |=> rst_irq_o);
  // R8
  no_sw_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |-> csr_we == '0 && !irq_clr);
  // R10
  one_csr_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(csr_we));
endmodule

bind usbd_busrst_regs usbd_busrst_regs_chk #(
  .NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CSR_W(CSR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst_i), .irq_clr(irq_clr),
  .csr_we(csr_we), .func_addr_o(func_addr_o), .ep_idx_o(ep_idx_o),
  .fifo_flush_o(fifo_flush_o), .ep_csr_o(ep_csr_o), .ep_ie_o(ep_ie_o),
  .rst_irq_o(rst_irq_o)
);

// File: tb/usbd_busrst_regs_tb.sv
module usbd_busrst_regs_tb;
  localparam int NE = 8;
  localparam int AW = 7;
  localparam int IW = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst_i = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [IW-1:0] wr_ep = '0;
  logic [CW-1:0] wr_data = '0;
  logic [AW-1:0] func_addr_o;
  logic [IW-1:0] ep_idx_o;
  logic [NE-1:0] fifo_flush_o;
  logic [NE*CW-1:0] ep_csr_o;
  logic [NE-1:0] ep_ie_o;
  logic rst_irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  usbd_busrst_regs #(.NUM_EP(NE), .ADDR_W(AW), .IDX_W(IW), .CSR_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst_i), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_ep(wr_ep), .wr_data(wr_data),
    .func_addr_o(func_addr_o), .ep_idx_o(ep_idx_o), .fifo_flush_o(fifo_flush_o),
    .ep_csr_o(ep_csr_o), .ep_ie_o(ep_ie_o), .rst_irq_o(rst_irq_o)
  );

  function automatic logic [CW-1:0] pat(input int i, input int k);
    return CW'((i * 29 + k * 7 + 3) % 256);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at falling edge, results checked one falling edge later
  task automatic step(input logic br, input logic we, input logic [2:0] sel,
                      input int ep, input logic [CW-1:0] d);
    bus_rst_i = br; wr_en = we; wr_sel = sel; wr_ep = IW'(ep); wr_data = d;
    @(negedge clk);
    bus_rst_i = 1'b0; wr_en = 1'b0;
  endtask

  task automatic chk_reset_bundle(input string tag);
    chk({tag, " R1 addr"}, 64'(func_addr_o), 64'd0);
    chk({tag, " R2 idx"}, 64'(ep_idx_o), 64'd0);
    chk({tag, " R3 flush"}, 64'(fifo_flush_o), 64'hff);
    chk({tag, " R4 csr"}, 64'(ep_csr_o), 64'd0);
    chk({tag, " R5 ie"}, 64'(ep_ie_o), 64'hff);
    chk({tag, " R6 irq"}, 64'(rst_irq_o), 64'd1);
  endtask

  task automatic load_all(input int k);
    step(1'b0, 1'b1, 3'd0, 0, CW'((k * 37 + 5) % 128));
    step(1'b0, 1'b1, 3'd1, 0, CW'((k + 3) % 16));
    step(1'b0, 1'b1, 3'd3, 0, CW'(8'h5a ^ k));
    for (int i = 0; i < NE; i++) step(1'b0, 1'b1, 3'd2, i, pat(i, k));
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R12 reset state
    chk("R12 addr", 64'(func_addr_o), 0);
    chk("R12 idx", 64'(ep_idx_o), 0);
    chk("R12 csr", 64'(ep_csr_o), 0);
    chk("R12 ie", 64'(ep_ie_o), 64'hff);
    chk("R12 flush", 64'(fifo_flush_o), 0);
    chk("R12 irq", 64'(rst_irq_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 sweep of address and index writes
    for (int a = 0; a < 128; a++) begin
      step(1'b0, 1'b1, 3'd0, 0, CW'(a));
      chk("R9 addr", 64'(func_addr_o), 64'(a));
    end
    for (int x = 0; x < 16; x++) begin
      step(1'b0, 1'b1, 3'd1, 0, CW'(x | 8'hf0));
      chk("R9 idx", 64'(ep_idx_o), 64'(x));
    end

    for (int k = 0; k < 4; k++) begin
      load_all(k);
      chk("R9 addr", 64'(func_addr_o), 64'((k * 37 + 5) % 128));
      chk("R9 idx", 64'(ep_idx_o), 64'((k + 3) % 16));
      chk("R9 ie", 64'(ep_ie_o), 64'(8'h5a ^ k));
      for (int i = 0; i < NE; i++)
        chk("R9 csr", 64'(ep_csr_o[i*CW +: CW]), 64'(pat(i, k)));
      chk("R11 no flush", 64'(fifo_flush_o), 0);
      // R10 out-of-range endpoint write
      for (int e = NE; e < 16; e++) begin
        step(1'b0, 1'b1, 3'd2, e, 8'hee);
        for (int i = 0; i < NE; i++)
          chk("R10 csr", 64'(ep_csr_o[i*CW +: CW]), 64'(pat(i, k)));
      end
      // bus reset; R8 when k odd, with a colliding write
      step(1'b1, k[0], 3'(k % 4), 1, 8'h7f);
      chk_reset_bundle(k[0] ? "R8" : "base");
      @(negedge clk);
      chk("R3 pulse width", 64'(fifo_flush_o), 0);
      chk("R7 sticky", 64'(rst_irq_o), 1);
      step(1'b0, 1'b1, 3'd4, 0, 8'hfe);
      chk("R7 write0", 64'(rst_irq_o), 1);
      if (k == 2) begin
        // R8: clear request collides with reset, irq must remain
        step(1'b1, 1'b1, 3'd4, 0, 8'h01);
        chk("R8 irq", 64'(rst_irq_o), 1);
        @(negedge clk);
      end
      step(1'b0, 1'b1, 3'd4, 0, 8'h01);
      chk("R7 clear", 64'(rst_irq_o), 0);
    end

    // back-to-back bus resets keep flush high
    step(1'b1, 1'b0, 3'd0, 0, 0);
    bus_rst_i = 1'b1;
    @(negedge clk);
    bus_rst_i = 1'b0;
    chk("R3 back-to-back", 64'(fifo_flush_o), 64'hff);
    @(negedge clk);
    chk("R11 after", 64'(fifo_flush_o), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule